// File: doc/BRIEF.md
# Radio Event Status Register

This block holds the sticky event flags of a packet radio. The transmit sequencer sends single-cycle pulses when the preamble ends, when the PHY header has gone out, and when the payload has finished. The receive chain sends pulses when a preamble is confirmed, when the start-of-frame delimiter is found, when the receive timestamp adjustment is complete, and when the header has been decoded. Each pulse sets its own flag, and the flag stays set until something clears it.

Flags can be cleared in three ways. Software writes ones to the status word over a simple register bus. A transmitter-enable pulse clears the transmit group of flags. A receiver-enable pulse, or an automatic receiver re-enable, clears the receive group. A mask word with the same bit layout chooses which flags drive one active-high interrupt line.

For a frame with no payload there is no payload-end pulse. While the zero-length qualifier is high, the frame-sent flag follows the header-sent flag by one cycle.

Top module: `radio_evt_status`

## Requirements
- R1: After reset, the status word, the mask word and `irq` are all zero.
- R2: A pulse on `txPreambleDone`, `txHeaderSent` or `txPayloadDone` that is sampled at a clock edge sets status bit 5, 6 or 7 respectively at that edge. The bit stays set until it is cleared.
- R3: A pulse on `rxPreambleSeen`, `rxSfdSeen`, `rxTsAdjDone` or `rxHeaderDone` sets status bit 8, 9, 10 or 11 respectively at the sampling edge. The bit stays set until it is cleared.
- R4: When `txHeaderSent` is sampled with `txZeroLen` high, bit 6 is set at that edge and bit 7 is set at the following edge. When `txZeroLen` is low, bit 7 is not set by the header pulse.
- R5: A bus write to the status address (0) clears every live bit whose write-data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R6: A `txEnable` pulse clears bits 5 to 7 and leaves bits 8 to 11 unchanged.
- R7: A pulse on `rxEnable` or on `rxAutoReenable` clears bits 8 to 11 and leaves bits 5 to 7 unchanged.
- R8: If an event pulse and any clear (a write of 1 or a group auto-clear) reach the same bit in the same cycle, the bit ends up set.
- R9: Bits 0 to 4 and 12 to 31 of the status word and of the mask word always read as zero. The mask address is 1. Any other address reads as zero, and a write to it has no effect.
- R10: `irq` is a register that holds the OR of (status AND mask) as it stood after the previous clock edge. It therefore follows a status or mask change by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Register word address (0 = status, 1 = mask) |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for `busAddr` |
| txPreambleDone | input | 1 | Pulse: the preamble has ended and the delimiter is starting |
| txHeaderSent | input | 1 | Pulse: the PHY header has been transmitted |
| txPayloadDone | input | 1 | Pulse: the payload has finished |
| txZeroLen | input | 1 | Qualifier: the current frame has no payload |
| rxPreambleSeen | input | 1 | Pulse: a preamble has been confirmed |
| rxSfdSeen | input | 1 | Pulse: the start-of-frame delimiter has been detected |
| rxTsAdjDone | input | 1 | Pulse: the receive timestamp adjustment is complete |
| rxHeaderDone | input | 1 | Pulse: header decoding is complete |
| txEnable | input | 1 | Pulse: the transmitter is being enabled |
| rxEnable | input | 1 | Pulse: the receiver is being enabled |
| rxAutoReenable | input | 1 | Pulse: the receiver is being re-enabled automatically |
| irq | output | 1 | Registered interrupt line |

## Verification
Event pulses, bus writes and auto-clears all take effect at the edge that samples them. The status and mask words can therefore be read combinationally half a cycle later. The one exception is the zero-length frame-sent flag, which appears one edge after the header-sent flag. `irq` lags the status and mask words by one more edge. The bench drives its inputs at the falling edge and updates its own expected model just after the rising edge. It reads back the registers and `irq` at the next falling edge. The directed checks step through the R4 and R10 delays one edge at a time, so a result that arrives early or late is caught.

// File: rtl/radio_evt_pkg.sv
package radio_evt_pkg;
  localparam int REG_W = 32;

  localparam int BIT_TX_PRE = 5;
  localparam int BIT_TX_HDR = 6;
  localparam int BIT_TX_FRM = 7;
  localparam int BIT_RX_PRE = 8;
  localparam int BIT_RX_SFD = 9;
  localparam int BIT_RX_TSA = 10;
  localparam int BIT_RX_HDR = 11;

  localparam logic [REG_W-1:0] TX_GROUP  = 32'h0000_00E0;
  localparam logic [REG_W-1:0] RX_GROUP  = 32'h0000_0F00;
  localparam logic [REG_W-1:0] LIVE_BITS = TX_GROUP | RX_GROUP;

  typedef struct packed {
    logic [REG_W-1:0] setBits;
    logic [REG_W-1:0] clrBits;
    logic             maskLoad;
    logic             rdStatus;
    logic             rdMask;
  } evt_strobe_t;
endpackage

// File: rtl/radio_evt_ctrl.sv
module radio_evt_ctrl
  import radio_evt_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int STATUS_ADDR = 0,
  parameter int MASK_ADDR   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [REG_W-1:0]  busWrData,
  input  logic              txPreambleDone,
  input  logic              txHeaderSent,
  input  logic              txPayloadDone,
  input  logic              txZeroLen,
  input  logic              rxPreambleSeen,
  input  logic              rxSfdSeen,
  input  logic              rxTsAdjDone,
  input  logic              rxHeaderDone,
  input  logic              txEnable,
  input  logic              rxEnable,
  input  logic              rxAutoReenable,
  output evt_strobe_t       strobe
);
  localparam logic [ADDR_W-1:0] StatusSel = ADDR_W'(STATUS_ADDR);
  localparam logic [ADDR_W-1:0] MaskSel   = ADDR_W'(MASK_ADDR);

  logic zeroLenPendQ;
  logic statusHit;
  logic maskHit;
  logic rxArm;

  // A header pulse on a frame with no payload stands in for the
  // missing payload-end pulse one cycle later.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) zeroLenPendQ <= 1'b0;
    else       zeroLenPendQ <= txHeaderSent & txZeroLen;
  end

  assign statusHit = (busAddr == StatusSel);
  assign maskHit   = (busAddr == MaskSel);
  assign rxArm     = rxEnable | rxAutoReenable;

  always_comb begin
    strobe = '0;
    strobe.setBits[BIT_TX_PRE] = txPreambleDone;
    strobe.setBits[BIT_TX_HDR] = txHeaderSent;
    strobe.setBits[BIT_TX_FRM] = txPayloadDone | zeroLenPendQ;
    strobe.setBits[BIT_RX_PRE] = rxPreambleSeen;
    strobe.setBits[BIT_RX_SFD] = rxSfdSeen;
    strobe.setBits[BIT_RX_TSA] = rxTsAdjDone;
    strobe.setBits[BIT_RX_HDR] = rxHeaderDone;
    strobe.clrBits = ((busWrEn && statusHit) ? busWrData : '0)
                   | (txEnable ? TX_GROUP : '0)
                   | (rxArm ? RX_GROUP : '0);
    strobe.clrBits  = strobe.clrBits & LIVE_BITS;
    strobe.maskLoad = busWrEn && maskHit;
    strobe.rdStatus = statusHit;
    strobe.rdMask   = maskHit;
  end
endmodule

// File: rtl/radio_evt_datapath.sv
module radio_evt_datapath
  import radio_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  evt_strobe_t      strobe,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] statusVec,
  output logic [REG_W-1:0] maskVec,
  output logic [REG_W-1:0] rdData,
  output logic             irq
);
  logic [REG_W-1:0] statusQ;
  logic [REG_W-1:0] statusNext;
  logic [REG_W-1:0] maskQ;
  logic             irqQ;

  // Each live bit: the set path dominates the clear path.
  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (LIVE_BITS[i]) begin : g_live
      assign statusNext[i] = strobe.setBits[i] | (statusQ[i] & ~strobe.clrBits[i]);
    end else begin : g_rsvd
      assign statusNext[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
      irqQ    <= 1'b0;
    end else begin
      statusQ <= statusNext;
      if (strobe.maskLoad) maskQ <= wrData & LIVE_BITS;
      irqQ <= |(statusQ & maskQ);
    end
  end

  always_comb begin
    if (strobe.rdStatus)    rdData = statusQ;
    else if (strobe.rdMask) rdData = maskQ;
    else                    rdData = '0;
  end

  assign statusVec = statusQ;
  assign maskVec   = maskQ;
  assign irq       = irqQ;
endmodule

// File: rtl/radio_evt_status.sv
module radio_evt_status
  import radio_evt_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int STATUS_ADDR = 0,
  parameter int MASK_ADDR   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              txPreambleDone,
  input  logic              txHeaderSent,
  input  logic              txPayloadDone,
  input  logic              txZeroLen,
  input  logic              rxPreambleSeen,
  input  logic              rxSfdSeen,
  input  logic              rxTsAdjDone,
  input  logic              rxHeaderDone,
  input  logic              txEnable,
  input  logic              rxEnable,
  input  logic              rxAutoReenable,
  output logic              irq
);
  evt_strobe_t      strobe;
  logic [REG_W-1:0] statusVec;
  logic [REG_W-1:0] maskVec;

  radio_evt_ctrl #(
    .ADDR_W     (ADDR_W),
    .STATUS_ADDR(STATUS_ADDR),
    .MASK_ADDR  (MASK_ADDR)
  ) ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .busAddr       (busAddr),
    .busWrEn       (busWrEn),
    .busWrData     (busWrData),
    .txPreambleDone(txPreambleDone),
    .txHeaderSent  (txHeaderSent),
    .txPayloadDone (txPayloadDone),
    .txZeroLen     (txZeroLen),
    .rxPreambleSeen(rxPreambleSeen),
    .rxSfdSeen     (rxSfdSeen),
    .rxTsAdjDone   (rxTsAdjDone),
    .rxHeaderDone  (rxHeaderDone),
    .txEnable      (txEnable),
    .rxEnable      (rxEnable),
    .rxAutoReenable(rxAutoReenable),
    .strobe        (strobe)
  );

  radio_evt_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (busWrData),
    .statusVec(statusVec),
    .maskVec  (maskVec),
    .rdData   (busRdData),
    .irq      (irq)
  );
endmodule

// File: rtl/radio_evt_status_chk.sv
module radio_evt_status_chk
  import radio_evt_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int STATUS_ADDR = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [31:0]       busWrData,
  input logic [31:0]       busRdData,
  input logic              txPreambleDone,
  input logic              txHeaderSent,
  input logic              txZeroLen,
  input logic              rxPreambleSeen,
  input logic              rxSfdSeen,
  input logic              txEnable,
  input logic              rxEnable,
  input logic              rxAutoReenable,
  input logic [31:0]       statusVec,
  input logic [31:0]       maskVec,
  input logic              irq
);
  a_r2_tx_header_sets: assert property (@(posedge clk) disable iff (!rstN)
    txHeaderSent |=> statusVec[BIT_TX_HDR]);

  a_r3_rx_sfd_sets: assert property (@(posedge clk) disable iff (!rstN)
    rxSfdSeen |=> statusVec[BIT_RX_SFD]);

  a_r4_zero_len_frame: assert property (@(posedge clk) disable iff (!rstN)
    (txHeaderSent && txZeroLen) |=> ##1 statusVec[BIT_TX_FRM]);

  a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(STATUS_ADDR) && busWrData[BIT_TX_PRE] && !txPreambleDone)
      |=> !statusVec[BIT_TX_PRE]);

  a_r6_tx_enable_clears: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && !txPreambleDone) |=> !statusVec[BIT_TX_PRE]);

  a_r7_rx_enable_clears: assert property (@(posedge clk) disable iff (!rstN)
    ((rxEnable || rxAutoReenable) && !rxPreambleSeen) |=> !statusVec[BIT_RX_PRE]);

  a_r8_event_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    (txPreambleDone && txEnable) |=> statusVec[BIT_TX_PRE]);

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRdData & ~LIVE_BITS) == '0);

  a_r10_irq_lag: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irq == $past(|(statusVec & maskVec))));
endmodule

bind radio_evt_status radio_evt_status_chk #(
  .ADDR_W     (ADDR_W),
  .STATUS_ADDR(STATUS_ADDR)
) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .busAddr       (busAddr),
  .busWrEn       (busWrEn),
  .busWrData     (busWrData),
  .busRdData     (busRdData),
  .txPreambleDone(txPreambleDone),
  .txHeaderSent  (txHeaderSent),
  .txZeroLen     (txZeroLen),
  .rxPreambleSeen(rxPreambleSeen),
  .rxSfdSeen     (rxSfdSeen),
  .txEnable      (txEnable),
  .rxEnable      (rxEnable),
  .rxAutoReenable(rxAutoReenable),
  .statusVec     (statusVec),
  .maskVec       (maskVec),
  .irq           (irq)
);

// File: tb/radio_evt_status_tb_top.sv
module radio_evt_status_tb_top;
  localparam int ADDR_W = 4;
  localparam logic [31:0] LIVE = 32'h0000_0FE0;
  localparam logic [31:0] TXG  = 32'h0000_00E0;
  localparam logic [31:0] RXG  = 32'h0000_0F00;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic txPreambleDone = 1'b0, txHeaderSent = 1'b0, txPayloadDone = 1'b0, txZeroLen = 1'b0;
  logic rxPreambleSeen = 1'b0, rxSfdSeen = 1'b0, rxTsAdjDone = 1'b0, rxHeaderDone = 1'b0;
  logic txEnable = 1'b0, rxEnable = 1'b0, rxAutoReenable = 1'b0;
  logic irq;

  int checkCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  logic [31:0] expStatus = '0;
  logic [31:0] expMask = '0;
  logic expIrq = 1'b0;
  logic expPend = 1'b0;

  always #4 clk = ~clk;

  radio_evt_status #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .txPreambleDone(txPreambleDone), .txHeaderSent(txHeaderSent),
    .txPayloadDone(txPayloadDone), .txZeroLen(txZeroLen),
    .rxPreambleSeen(rxPreambleSeen), .rxSfdSeen(rxSfdSeen),
    .rxTsAdjDone(rxTsAdjDone), .rxHeaderDone(rxHeaderDone),
    .txEnable(txEnable), .rxEnable(rxEnable), .rxAutoReenable(rxAutoReenable),
    .irq(irq)
  );

  function automatic logic [31:0] eventSet(logic pend);
    logic [31:0] s;
    s = '0;
    s[5] = txPreambleDone;
    s[6] = txHeaderSent;
    s[7] = txPayloadDone | pend;
    s[8] = rxPreambleSeen;
    s[9] = rxSfdSeen;
    s[10] = rxTsAdjDone;
    s[11] = rxHeaderDone;
    return s;
  endfunction

  function automatic logic [31:0] clearSet();
    logic [31:0] c;
    c = (busWrEn && busAddr == 0) ? busWrData : '0;
    if (txEnable) c = c | TXG;
    if (rxEnable || rxAutoReenable) c = c | RXG;
    return c & LIVE;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    txPreambleDone = 0; txHeaderSent = 0; txPayloadDone = 0; txZeroLen = 0;
    rxPreambleSeen = 0; rxSfdSeen = 0; rxTsAdjDone = 0; rxHeaderDone = 0;
    txEnable = 0; rxEnable = 0; rxAutoReenable = 0; busWrEn = 0;
  endtask

  task automatic cycle();
    logic [31:0] s;
    logic [31:0] c;
    @(posedge clk); #1;
    s = eventSet(expPend);
    c = clearSet();
    expIrq = |(expStatus & expMask);
    expPend = txHeaderSent & txZeroLen;
    if (busWrEn && busAddr == 1) expMask = busWrData & LIVE;
    expStatus = ((expStatus & ~c) | s) & LIVE;
    @(negedge clk);
    quiet();
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    busAddr = ADDR_W'(a); #1; v = busRdData;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    busAddr = ADDR_W'(a); busWrEn = 1; busWrData = d; cycle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    rd(0, v); check("R1 status", v, 32'h0);
    rd(1, v); check("R1 mask", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    // R9 mask layout and unmapped address
    wr(1, 32'hFFFF_FFFF);
    rd(1, v); check("R9 mask live bits", v, 32'h0000_0FE0);
    wr(2, 32'hFFFF_FFFF);
    rd(2, v); check("R9 unmapped reads zero", v, 32'h0);
    rd(1, v); check("R9 unmapped write ignored", v, 32'h0000_0FE0);
    // R2 / R10
    txPreambleDone = 1; cycle();
    rd(0, v); check("R2 preamble bit", v, 32'h0000_0020);
    check("R10 irq lags", {31'b0, irq}, 32'h0);
    cycle();
    check("R10 irq rises", {31'b0, irq}, 32'h1);
    txHeaderSent = 1; txPayloadDone = 1; cycle();
    rd(0, v); check("R2 all tx bits", v, 32'h0000_00E0);
    // R5 write-one-to-clear
    wr(0, 32'h0);
    rd(0, v); check("R5 zero write no effect", v, 32'h0000_00E0);
    wr(0, 32'h0000_0040);
    rd(0, v); check("R5 clears bit 6 only", v, 32'h0000_00A0);
    // R3
    rxPreambleSeen = 1; rxSfdSeen = 1; rxTsAdjDone = 1; rxHeaderDone = 1; cycle();
    rd(0, v); check("R3 rx bits", v, 32'h0000_0FA0);
    // R6
    txEnable = 1; cycle();
    rd(0, v); check("R6 tx group cleared", v, 32'h0000_0F00);
    // R8
    txEnable = 1; txPreambleDone = 1; cycle();
    rd(0, v); check("R8 event beats tx enable", v, 32'h0000_0F20);
    rxEnable = 1; rxSfdSeen = 1; cycle();
    rd(0, v); check("R8 event beats rx enable", v, 32'h0000_0220);
    // R7
    rxAutoReenable = 1; cycle();
    rd(0, v); check("R7 auto re-enable clears rx", v, 32'h0000_0020);
    busAddr = 0; busWrEn = 1; busWrData = 32'h20; txPreambleDone = 1; cycle();
    rd(0, v); check("R8 event beats write", v, 32'h0000_0020);
    wr(0, 32'hFFFF_FFFF);
    rd(0, v); check("R5 clear all", v, 32'h0);
    // R4 zero-length frame
    txHeaderSent = 1; txZeroLen = 1; cycle();
    rd(0, v); check("R4 header first", v, 32'h0000_0040);
    cycle();
    rd(0, v); check("R4 frame follows", v, 32'h0000_00C0);
    wr(0, 32'hFFFF_FFFF);
    txHeaderSent = 1; cycle(); cycle();
    rd(0, v); check("R4 nonzero length no frame", v, 32'h0000_0040);
    // R10 mask off
    cycle();
    check("R10 irq high", {31'b0, irq}, 32'h1);
    wr(1, 32'h0);
    check("R10 irq still high", {31'b0, irq}, 32'h1);
    cycle();
    check("R10 irq masked", {31'b0, irq}, 32'h0);
    // random phase against the bench model
    void'($urandom(32'd1234));
    for (int n = 0; n < 400; n++) begin
      txPreambleDone = ($urandom % 6) == 0;
      txHeaderSent = ($urandom % 6) == 0;
      txPayloadDone = ($urandom % 6) == 0;
      txZeroLen = ($urandom % 3) == 0;
      rxPreambleSeen = ($urandom % 6) == 0;
      rxSfdSeen = ($urandom % 6) == 0;
      rxTsAdjDone = ($urandom % 6) == 0;
      rxHeaderDone = ($urandom % 6) == 0;
      txEnable = ($urandom % 10) == 0;
      rxEnable = ($urandom % 12) == 0;
      rxAutoReenable = ($urandom % 12) == 0;
      busWrEn = ($urandom % 5) == 0;
      busAddr = ADDR_W'($urandom % 3);
      busWrData = $urandom;
      cycle();
      rd(0, v); check("R8 random status", v, expStatus);
      rd(1, v); check("R9 random mask", v, expMask);
      check("R10 random irq", {31'b0, irq}, {31'b0, expIrq});
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end
endmodule